// File: doc/BRIEF.md
# Track Format Byte Translator

This block runs the byte stream of a full-track format write for a floppy disk controller. Once a command starts, it asks the host for data with a request flag. It waits for the index pulse and then emits exactly one on-disk byte per byte-time tick until the programmed track length has been written. A few host byte values act as control codes and are not written as given. One becomes an A1 sync byte with a missing clock. Another becomes a C2 index sync byte with a missing clock. A third becomes the two-byte running CRC. Flux and clock-bit generation are not part of this block: a missing-clock mark appears only as a side flag on the output byte.

The host loads a byte while the request flag is high. Each tick then consumes the held byte. If no byte is held, a zero byte is written and lost-data is flagged. The CRC is CRC-16 with polynomial 0x1021, preset to 0xFFFF when the command starts. A byte strobe appears on the outputs in the cycle after the tick that produced it. Each output byte has a missing-clock flag and an ID-address-mark flag beside it.

Top module: `fmt_track_writer`

## Requirements
- R1: A start pulse with write-protect high sets the write-protect status, raises the interrupt, leaves busy and the request flag low and writes no byte.
- R2: After reset, busy, request, interrupt, lost-data and write-protect status are low. A start pulse with write-protect low raises busy and the request flag in the next cycle and clears the interrupt and lost-data.
- R3: A host write while the request flag is high stores the byte and drops the request flag. A host write while the flag is low is ignored and cannot reach the disk.
- R4: If no host byte is held when the index pulse arrives, lost-data is set and the command ends without any output byte.
- R5: Host code 0xF5 is written as 0xA1 with the missing-clock flag. The CRC is first preset to its value after two 0xA1 bytes from 0xFFFF and then updated with this 0xA1, so three such codes give the CRC of three A1 bytes.
- R6: Host code 0xF6 is written as 0xC2 with the missing-clock flag.
- R7: Host code 0xF7 is written as the CRC high byte, and the following slot carries the CRC low byte taken from the same CRC value. The CRC keeps running over both bytes, so the CRC over the whole written record ends at zero.
- R8: The slot that carries the CRC low byte raises no request and does not translate its byte.
- R9: A 0xFE host byte written straight after a translated 0xA1 is output as 0xFE with the ID-address-mark flag. No other byte carries that flag.
- R10: After each tick that leaves slots to fill, the request flag is raised again (except R8). A slot with no held byte is written as 0x00, and lost-data is set.
- R11: Exactly track-length bytes are written after the index pulse. Then busy and the request flag fall and the interrupt rises.
- R12: The missing-clock flag is high only with a translated 0xA1 or 0xC2 byte and low for every other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle command start pulse |
| wprot_i | input | 1 | Disk write-protect level |
| index_i | input | 1 | One-cycle index pulse |
| byte_tick_i | input | 1 | One-cycle byte-time strobe |
| cpu_wr_i | input | 1 | Host writes the data register |
| cpu_data_i | input | 8 | Host data byte |
| track_len_i | input | LEN_W | Bytes per track (at least 1) |
| drq_o | output | 1 | Data request to the host |
| busy_o | output | 1 | Command in progress |
| irq_o | output | 1 | Command ended |
| lost_data_o | output | 1 | A byte was missing |
| wprot_err_o | output | 1 | Command refused by write protect |
| out_valid_o | output | 1 | On-disk byte strobe |
| out_byte_o | output | 8 | On-disk byte value |
| out_mclk_o | output | 1 | Byte carries a missing clock |
| out_idam_o | output | 1 | Byte is an ID address mark |

## Verification
On every cycle the assertions check these rules: how a start pulse responds to write protect, that an accepted host write drops the request, and that the request is only seen while busy. They also check that the missing-clock and ID-mark flags only ever come with the byte values allowed for them, and that the interrupt is up when busy falls. The byte sequence itself needs the bench's scenarios: control-code translation, the CRC value and the zero CRC residue, the ignored write during the second CRC slot, zero filling with lost-data, and the exact byte count per track.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_IDX = 2'd1,
        ST_WRITE    = 2'd2
    } fmt_state_e;

    localparam int          BYTE_W     = 8;
    localparam int          CRC_W      = 16;
    localparam logic [15:0] CRC_POLY   = 16'h1021;
    localparam logic [15:0] CRC_INIT   = 16'hFFFF;

    localparam logic [7:0]  CODE_SYNC  = 8'hF5;
    localparam logic [7:0]  CODE_ISYNC = 8'hF6;
    localparam logic [7:0]  CODE_CRC   = 8'hF7;
    localparam logic [7:0]  BYTE_A1    = 8'hA1;
    localparam logic [7:0]  BYTE_C2    = 8'hC2;
    localparam logic [7:0]  BYTE_IDAM  = 8'hFE;

    function automatic logic [15:0] crc_byte(input logic [15:0] c,
                                             input logic [7:0]  b);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    // CRC value after two A1 sync bytes from the preset
    localparam logic [15:0] CRC_A1A1 = crc_byte(crc_byte(CRC_INIT, BYTE_A1), BYTE_A1);

endpackage

// File: rtl/fmt_crc_step.sv
module fmt_crc_step #(
    parameter int          W      = 16,
    parameter int          DW     = 8,
    parameter logic [W-1:0] POLY  = 16'h1021
) (
    input  logic [W-1:0]  crc_i,
    input  logic [DW-1:0] data_i,
    output logic [W-1:0]  crc_o
);
    logic [DW:0][W-1:0] chain;

    assign chain[0] = crc_i;

    for (genvar g = 0; g < DW; g++) begin : g_bit
        logic fb;
        assign fb         = chain[g][W-1] ^ data_i[DW-1-g];
        assign chain[g+1] = {chain[g][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_o = chain[DW];
endmodule

// File: rtl/fmt_xlate.sv
module fmt_xlate
    import fmt_pkg::*;
(
    input  logic [7:0]  pend_i,
    input  logic        slot2_i,
    input  logic        prev_a1_i,
    input  logic [15:0] crc_i,
    output logic [7:0]  byte_o,
    output logic        mclk_o,
    output logic        idam_o,
    output logic        is_a1_o,
    output logic        is_crc_o,
    output logic [15:0] crc_base_o
);
    always_comb begin
        byte_o     = pend_i;
        mclk_o     = 1'b0;
        idam_o     = 1'b0;
        is_a1_o    = 1'b0;
        is_crc_o   = 1'b0;
        crc_base_o = crc_i;
        if (!slot2_i) begin
            unique case (pend_i)
                CODE_SYNC: begin
                    byte_o     = BYTE_A1;
                    mclk_o     = 1'b1;
                    is_a1_o    = 1'b1;
                    crc_base_o = CRC_A1A1;
                end
                CODE_ISYNC: begin
                    byte_o = BYTE_C2;
                    mclk_o = 1'b1;
                end
                CODE_CRC: begin
                    byte_o   = crc_i[15:8];
                    is_crc_o = 1'b1;
                end
                BYTE_IDAM: idam_o = prev_a1_i;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fmt_track_writer.sv
module fmt_track_writer
    import fmt_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             wprot_i,
    input  logic             index_i,
    input  logic             byte_tick_i,
    input  logic             cpu_wr_i,
    input  logic [7:0]       cpu_data_i,
    input  logic [LEN_W-1:0] track_len_i,
    output logic             drq_o,
    output logic             busy_o,
    output logic             irq_o,
    output logic             lost_data_o,
    output logic             wprot_err_o,
    output logic             out_valid_o,
    output logic [7:0]       out_byte_o,
    output logic             out_mclk_o,
    output logic             out_idam_o
);
    localparam logic [LEN_W-1:0] LAST_SLOT = LEN_W'(1);

    typedef struct packed {
        fmt_state_e          state;
        logic [BYTE_W-1:0]   held;
        logic                written;
        logic [BYTE_W-1:0]   pend;
        logic                slot2;
        logic                prev_a1;
        logic [CRC_W-1:0]    crc;
        logic [LEN_W-1:0]    remain;
        logic                drq;
        logic                busy;
        logic                irq;
        logic                lost;
        logic                wp_err;
        logic                ov;
        logic [BYTE_W-1:0]   ob;
        logic                omc;
        logic                oid;
    } fmt_regs_t;

    fmt_regs_t q, d;

    logic [7:0]  xl_byte;
    logic        xl_mclk, xl_idam, xl_is_a1, xl_is_crc;
    logic [15:0] xl_base, crc_next;

    fmt_xlate u_xlate (
        .pend_i     (q.pend),
        .slot2_i    (q.slot2),
        .prev_a1_i  (q.prev_a1),
        .crc_i      (q.crc),
        .byte_o     (xl_byte),
        .mclk_o     (xl_mclk),
        .idam_o     (xl_idam),
        .is_a1_o    (xl_is_a1),
        .is_crc_o   (xl_is_crc),
        .crc_base_o (xl_base)
    );

    fmt_crc_step #(.W(CRC_W), .DW(BYTE_W), .POLY(CRC_POLY)) u_crc (
        .crc_i  (xl_base),
        .data_i (xl_byte),
        .crc_o  (crc_next)
    );

    always_comb begin
        d     = q;
        d.ov  = 1'b0;
        d.omc = 1'b0;
        d.oid = 1'b0;
        if (start_i) begin
            d.lost    = 1'b0;
            d.irq     = 1'b0;
            d.wp_err  = 1'b0;
            d.written = 1'b0;
            d.slot2   = 1'b0;
            d.prev_a1 = 1'b0;
            d.crc     = CRC_INIT;
            if (wprot_i) begin
                d.wp_err = 1'b1;
                d.irq    = 1'b1;
                d.busy   = 1'b0;
                d.drq    = 1'b0;
                d.state  = ST_IDLE;
            end else begin
                d.busy  = 1'b1;
                d.drq   = 1'b1;
                d.state = ST_WAIT_IDX;
            end
        end else begin
            unique case (q.state)
                ST_WAIT_IDX: begin
                    if (index_i) begin
                        if (!q.written) begin
                            d.lost  = 1'b1;
                            d.state = ST_IDLE;
                            d.busy  = 1'b0;
                            d.irq   = 1'b1;
                            d.drq   = 1'b0;
                        end else begin
                            d.pend    = q.held;
                            d.written = 1'b0;
                            d.drq     = 1'b1;
                            d.remain  = track_len_i;
                            d.state   = ST_WRITE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (byte_tick_i) begin
                        d.ov      = 1'b1;
                        d.ob      = xl_byte;
                        d.omc     = xl_mclk;
                        d.oid     = xl_idam;
                        d.crc     = crc_next;
                        d.prev_a1 = xl_is_a1;
                        d.slot2   = 1'b0;
                        d.remain  = q.remain - LAST_SLOT;
                        if (q.remain == LAST_SLOT) begin
                            d.state = ST_IDLE;
                            d.busy  = 1'b0;
                            d.irq   = 1'b1;
                            d.drq   = 1'b0;
                        end else if (xl_is_crc) begin
                            d.pend  = q.crc[7:0];
                            d.slot2 = 1'b1;
                            d.drq   = 1'b0;
                        end else begin
                            d.drq = 1'b1;
                            if (q.written) begin
                                d.pend    = q.held;
                                d.written = 1'b0;
                            end else begin
                                d.pend = '0;
                                d.lost = 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
            if (cpu_wr_i && q.drq) begin
                d.held    = cpu_data_i;
                d.written = 1'b1;
                d.drq     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign drq_o       = q.drq;
    assign busy_o      = q.busy;
    assign irq_o       = q.irq;
    assign lost_data_o = q.lost;
    assign wprot_err_o = q.wp_err;
    assign out_valid_o = q.ov;
    assign out_byte_o  = q.ob;
    assign out_mclk_o  = q.omc;
    assign out_idam_o  = q.oid;
endmodule

// File: rtl/fmt_track_writer_chk.sv
module fmt_track_writer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       wprot_i,
    input logic       cpu_wr_i,
    input logic       drq_o,
    input logic       busy_o,
    input logic       irq_o,
    input logic       lost_data_o,
    input logic       wprot_err_o,
    input logic       out_valid_o,
    input logic [7:0] out_byte_o,
    input logic       out_mclk_o,
    input logic       out_idam_o
);
    // R1
    wprot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && wprot_i |=> !busy_o && !drq_o && wprot_err_o && irq_o);

    // R2
    start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !wprot_i |=> busy_o && drq_o && !irq_o && !lost_data_o);

    // R3
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_i && drq_o && !start_i |=> !drq_o);

    // R9
    idam_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_idam_o |-> out_valid_o && out_byte_o == 8'hFE && !out_mclk_o);

    // R12
    mclk_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_mclk_o |-> out_valid_o && (out_byte_o == 8'hA1 || out_byte_o == 8'hC2));

    // R11
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> irq_o && !drq_o);

    // R10
    drq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drq_o |-> busy_o);

    // R4
    out_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(busy_o));
endmodule

bind fmt_track_writer fmt_track_writer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .wprot_i     (wprot_i),
    .cpu_wr_i    (cpu_wr_i),
    .drq_o       (drq_o),
    .busy_o      (busy_o),
    .irq_o       (irq_o),
    .lost_data_o (lost_data_o),
    .wprot_err_o (wprot_err_o),
    .out_valid_o (out_valid_o),
    .out_byte_o  (out_byte_o),
    .out_mclk_o  (out_mclk_o),
    .out_idam_o  (out_idam_o)
);

// File: tb/fmt_track_writer_tb.sv
module fmt_track_writer_tb;
    localparam int LW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, wprot_i = 1'b0, index_i = 1'b0;
    logic          byte_tick_i = 1'b0, cpu_wr_i = 1'b0;
    logic [7:0]    cpu_data_i = 8'h00;
    logic [LW-1:0] track_len_i = '0;
    logic          drq_o, busy_o, irq_o, lost_data_o, wprot_err_o;
    logic          out_valid_o, out_mclk_o, out_idam_o;
    logic [7:0]    out_byte_o;

    always #5 clk = ~clk;

    fmt_track_writer #(.LEN_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wprot_i(wprot_i),
        .index_i(index_i), .byte_tick_i(byte_tick_i), .cpu_wr_i(cpu_wr_i),
        .cpu_data_i(cpu_data_i), .track_len_i(track_len_i),
        .drq_o(drq_o), .busy_o(busy_o), .irq_o(irq_o),
        .lost_data_o(lost_data_o), .wprot_err_o(wprot_err_o),
        .out_valid_o(out_valid_o), .out_byte_o(out_byte_o),
        .out_mclk_o(out_mclk_o), .out_idam_o(out_idam_o)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int tb_crc(input int c, input int b);
        int r = c;
        for (int i = 7; i >= 0; i--) begin
            if ((((r >> 15) & 1) ^ ((b >> i) & 1)) != 0) r = ((r << 1) ^ 'h1021) & 'hFFFF;
            else                                         r = (r << 1) & 'hFFFF;
        end
        return r;
    endfunction

    // ---------------- behavioural reference model ----------------
    int m_phase;   // 0 idle, 1 waiting for index, 2 writing
    int m_held, m_pend, m_crc, m_remain, m_ob;
    bit m_written, m_slot2, m_prev_a1;
    bit m_drq, m_busy, m_irq, m_lost, m_wp, m_ov, m_mc, m_id;

    task automatic m_finish();
        m_phase = 0; m_busy = 0; m_irq = 1; m_drq = 0; m_slot2 = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_held = 0; m_pend = 0; m_crc = 0; m_remain = 0; m_ob = 0;
            m_written = 0; m_slot2 = 0; m_prev_a1 = 0;
            m_drq = 0; m_busy = 0; m_irq = 0; m_lost = 0; m_wp = 0;
            m_ov = 0; m_mc = 0; m_id = 0;
        end else begin
            bit had_drq;
            had_drq = m_drq;
            m_ov = 0; m_mc = 0; m_id = 0;
            if (start_i) begin
                m_lost = 0; m_irq = 0; m_wp = 0; m_written = 0;
                m_slot2 = 0; m_prev_a1 = 0; m_crc = 'hFFFF;
                if (wprot_i) begin
                    m_wp = 1; m_irq = 1; m_busy = 0; m_drq = 0; m_phase = 0;
                end else begin
                    m_busy = 1; m_drq = 1; m_phase = 1;
                end
            end else begin
                if (m_phase == 1 && index_i) begin
                    if (!m_written) begin
                        m_lost = 1; m_finish();
                    end else begin
                        m_pend = m_held; m_written = 0; m_drq = 1;
                        m_remain = int'(track_len_i); m_phase = 2;
                    end
                end else if (m_phase == 2 && byte_tick_i) begin
                    int  b;
                    int  lo_next;
                    bit  was_crc;
                    bit  a1_now;
                    was_crc = 0; a1_now = 0; lo_next = 0; b = m_pend;
                    if (m_slot2) begin
                        m_crc = tb_crc(m_crc, b);
                    end else if (m_pend == 'hF5) begin
                        b = 'hA1; m_mc = 1; a1_now = 1;
                        m_crc = tb_crc(tb_crc(tb_crc('hFFFF, 'hA1), 'hA1), 'hA1);
                    end else if (m_pend == 'hF6) begin
                        b = 'hC2; m_mc = 1;
                        m_crc = tb_crc(m_crc, b);
                    end else if (m_pend == 'hF7) begin
                        b = (m_crc >> 8) & 'hFF; lo_next = m_crc & 'hFF; was_crc = 1;
                        m_crc = tb_crc(m_crc, b);
                    end else begin
                        if (m_pend == 'hFE && m_prev_a1) m_id = 1;
                        m_crc = tb_crc(m_crc, b);
                    end
                    m_ov = 1; m_ob = b; m_prev_a1 = a1_now; m_slot2 = 0;
                    m_remain = m_remain - 1;
                    if (m_remain == 0) m_finish();
                    else if (was_crc) begin
                        m_pend = lo_next; m_slot2 = 1; m_drq = 0;
                    end else begin
                        m_drq = 1;
                        if (m_written) begin m_pend = m_held; m_written = 0; end
                        else begin m_pend = 0; m_lost = 1; end
                    end
                end
                if (cpu_wr_i && had_drq) begin
                    m_held = int'(cpu_data_i); m_written = 1; m_drq = 0;
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            chk(drq_o == m_drq,          "R10 drq",        drq_o, m_drq);
            chk(busy_o == m_busy,        "R11 busy",       busy_o, m_busy);
            chk(irq_o == m_irq,          "R11 irq",        irq_o, m_irq);
            chk(lost_data_o == m_lost,   "R10 lost",       lost_data_o, m_lost);
            chk(wprot_err_o == m_wp,     "R1 wprot",       wprot_err_o, m_wp);
            chk(out_valid_o == m_ov,     "R11 out_valid",  out_valid_o, m_ov);
            if (m_ov) chk(out_byte_o == m_ob[7:0], "R5 out_byte", out_byte_o, m_ob);
            chk(out_mclk_o == m_mc,      "R12 mclk",       out_mclk_o, m_mc);
            chk(out_idam_o == m_id,      "R9 idam",        out_idam_o, m_id);
        end
    end

    // ---------------- stimulus driver ----------------
    logic [7:0] fq[$];
    logic [7:0] cap_b[$];
    bit         cap_m[$];
    bit         cap_i[$];
    bit         tick_en = 0, feed_en = 0, inject_en = 0, injected = 0;
    int         tcnt = 0;

    always @(negedge clk) begin
        tcnt = (tcnt + 1) % 8;
        byte_tick_i <= tick_en && (tcnt == 0);
        if (out_valid_o) begin
            cap_b.push_back(out_byte_o);
            cap_m.push_back(out_mclk_o);
            cap_i.push_back(out_idam_o);
        end
        if (inject_en && !injected && busy_o && !drq_o && out_valid_o) begin
            cpu_wr_i   <= 1'b1;
            cpu_data_i <= 8'h55;
            injected   = 1;
        end else if (feed_en && drq_o && fq.size() > 0) begin
            cpu_wr_i   <= 1'b1;
            cpu_data_i <= fq.pop_front();
        end else begin
            cpu_wr_i <= 1'b0;
        end
    end

    task automatic pulse_start(input bit wp);
        @(negedge clk); wprot_i = wp; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic pulse_index();
        @(negedge clk); index_i = 1'b1;
        @(negedge clk); index_i = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (irq_o) break;
        end
        @(negedge clk);
    endtask

    task automatic clear_cap();
        cap_b.delete(); cap_m.delete(); cap_i.delete();
    endtask

    task automatic run_all();
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk(!busy_o && !drq_o && !irq_o && !lost_data_o && !wprot_err_o,
            "R2 reset state", {busy_o, drq_o, irq_o, lost_data_o}, 0);

        // R1 write protected
        clear_cap();
        pulse_start(1'b1);
        chk(wprot_err_o && irq_o && !busy_o && !drq_o, "R1 refused",
            {wprot_err_o, irq_o, busy_o, drq_o}, 4'b1100);
        repeat (20) @(negedge clk);
        chk(cap_b.size() == 0, "R1 no bytes", cap_b.size(), 0);
        wprot_i = 1'b0;

        // R2 arm, R4 nothing loaded before index
        tick_en = 1;
        pulse_start(1'b0);
        chk(busy_o && drq_o && !irq_o, "R2 armed", {busy_o, drq_o, irq_o}, 3'b110);
        repeat (5) @(negedge clk);
        pulse_index();
        chk(lost_data_o && irq_o && !busy_o, "R4 lost at index",
            {lost_data_o, irq_o, busy_o}, 3'b110);
        repeat (20) @(negedge clk);
        chk(cap_b.size() == 0, "R4 no bytes", cap_b.size(), 0);

        // R5 R7 R9 R11 R12: full record with sync, mark and CRC
        clear_cap();
        track_len_i = LW'(10);
        fq = '{8'hF5, 8'hF5, 8'hF5, 8'hFE, 8'h01, 8'h02, 8'h03, 8'h04, 8'hF7};
        feed_en = 1;
        pulse_start(1'b0);
        repeat (4) @(negedge clk);
        pulse_index();
        wait_done();
        chk(cap_b.size() == 10, "R11 byte count", cap_b.size(), 10);
        if (cap_b.size() == 10) begin
            for (int i = 0; i < 3; i++) begin
                chk(cap_b[i] == 8'hA1, "R5 sync byte", cap_b[i], 'hA1);
                chk(cap_m[i] == 1'b1,  "R5 missing clock", cap_m[i], 1);
            end
            chk(cap_b[3] == 8'hFE && cap_i[3], "R9 id mark", {cap_i[3], cap_b[3]}, 'h1FE);
            for (int i = 3; i < 10; i++)
                chk(cap_m[i] == 1'b0, "R12 clock flag clear", cap_m[i], 0);
            for (int i = 0; i < 10; i++)
                if (i != 3) chk(cap_i[i] == 1'b0, "R9 no mark", cap_i[i], 0);
            c = 'hFFFF;
            for (int i = 0; i < 8; i++) c = tb_crc(c, cap_b[i]);
            chk(cap_b[8] == c[15:8], "R7 crc high", cap_b[8], c[15:8]);
            chk(cap_b[9] == c[7:0],  "R7 crc low",  cap_b[9], c[7:0]);
            c = 'hFFFF;
            for (int i = 0; i < 10; i++) c = tb_crc(c, cap_b[i]);
            chk(c == 0, "R7 residue", c, 0);
        end
        chk(!lost_data_o && irq_o && !busy_o && !drq_o, "R11 clean end",
            {lost_data_o, irq_o, busy_o, drq_o}, 4'b0100);

        // R3 R6 R8 R10: ignored write in CRC low slot, zero fill
        clear_cap();
        track_len_i = LW'(4);
        fq = '{8'hF7, 8'hF6};
        inject_en = 1; injected = 0;
        pulse_start(1'b0);
        repeat (4) @(negedge clk);
        pulse_index();
        wait_done();
        chk(injected, "R3 write offered while request low", injected, 1);
        chk(cap_b.size() == 4, "R11 byte count short", cap_b.size(), 4);
        if (cap_b.size() == 4) begin
            chk(cap_b[0] == 8'hFF && cap_b[1] == 8'hFF, "R8 crc pair",
                {cap_b[0], cap_b[1]}, 'hFFFF);
            chk(cap_b[2] == 8'hC2 && cap_m[2], "R6 index sync", {cap_m[2], cap_b[2]}, 'h1C2);
            chk(cap_b[2] != 8'h55, "R3 ignored write", cap_b[2], 'hC2);
            chk(cap_b[3] == 8'h00 && !cap_m[3], "R10 zero fill", cap_b[3], 0);
        end
        chk(lost_data_o, "R10 lost flag", lost_data_o, 1);
        inject_en = 0; feed_en = 0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule